// File: doc/BRIEF.md
# Sliding Window Jet Finder

This block examines an 8x8 patch of calorimeter towers and reports a jet classification for each of the 4x4 towers at its centre. Every tower value is the sum of its electromagnetic and hadronic energies. For each of the sixteen candidates the block forms the 3x3 sum around it. A candidate survives only if that sum is a local maximum among the 3x3 sums centred on its eight neighbours. For a survivor, the 5x5 energy around it is compared with seven programmable thresholds. Each candidate gets a 3-bit code, and the sixteen codes leave on one serial line as four 12-bit words.

A frame is presented for one cycle with `frame_valid`. It passes through two register stages: the tower adder, then the window and threshold logic. A two-state transmitter then shifts it out. The transmitter sits in `SER_IDLE` until a staged frame appears. It then takes the transition to `SER_SEND` and stays there for 48 bit times. After the final bit it takes the transition back to `SER_IDLE`. A frame that reaches the transmitter while it is in `SER_SEND` is discarded.

Top module: `jet_window_finder`

## Requirements
- R1: Each tower value is the full-width sum of the electromagnetic and hadronic inputs. It is 9 bits wide for 8-bit inputs, so the sum never wraps. Tower (r,c), with row 0 at the top, sits at bits [(r*8+c)*8 +: 8] of each input vector.
- R2: The candidates are input rows 2..5 and columns 2..5. A candidate's 3x3 sum must be strictly greater than the 3x3 sums centred on its neighbours in the row above and on its left neighbour. It must be greater than or equal to the sums centred on its right neighbour and on its neighbours in the row below. A candidate that fails this test gets code 0.
- R3: The energy of a surviving candidate is the sum over the 5x5 towers centred on it. This includes the corner towers of the 8x8 area.
- R4: The code of a surviving candidate is the number of thresholds, among seven, that its energy is greater than or equal to (0 to 7). The thresholds need not be sorted. Threshold k is 14 bits at bits [k*14 +: 14] of `thr_flat`.
- R5: The 48 bits are sent as four 12-bit words, one per candidate row, top row first. Within a word the codes of columns 0..3 are placed from the most significant bit down. Each word is sent most significant bit first. `word_start` is high on bits 0, 12, 24 and 36 only.
- R6: If `frame_valid` is sampled high at clock edge k while the transmitter is idle, `ser_valid` is high after edges k+2 through k+49 (48 bit times). It is low again after edge k+50.
- R7: A frame whose staged result reaches the transmitter while it is in `SER_SEND` is dropped. This includes the cycle that carries the last bit. No second burst follows.
- R8: After reset, and whenever `ser_valid` is low, `ser_bit` and `word_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe: input frame present |
| em_flat | input | 512 | 64 electromagnetic tower energies, 8 bits each |
| had_flat | input | 512 | 64 hadronic tower energies, 8 bits each |
| thr_flat | input | 98 | Seven 14-bit jet thresholds |
| ser_bit | output | 1 | Serial code data |
| ser_valid | output | 1 | High while a bit is being sent |
| word_start | output | 1 | High on the first bit of each 12-bit word |

## Verification
Two functions can land on the same cycle: the transmitter emitting the final bits of one frame, and a newly staged frame arriving and asking to be loaded. The bench injects a second frame early in a burst, and again timed so that its load request coincides with the 48th bit. In both cases it judges that the first burst completes unchanged with 48 bits. It also checks that no second burst follows. A frame sent only after the line returns to idle must still be accepted with the documented latency.

// File: rtl/jwf_pkg.sv
package jwf_pkg;
    typedef enum logic [0:0] {
        SER_IDLE = 1'b0,
        SER_SEND = 1'b1
    } ser_state_t;
endpackage

// File: rtl/jwf_tower_add.sv
module jwf_tower_add #(
    parameter int TW = 8,
    parameter int G  = 8,
    localparam int CW = TW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [G*G*TW-1:0] em_flat,
    input  logic [G*G*TW-1:0] had_flat,
    output logic              out_valid,
    output logic [G*G*CW-1:0] tw_flat
);
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    for (genvar t = 0; t < G*G; t++) begin : g_tower
        always_ff @(posedge clk) begin
            if (in_valid)
                tw_flat[t*CW +: CW] <= CW'(em_flat[t*TW +: TW]) + CW'(had_flat[t*TW +: TW]);
        end
    end
endmodule

// File: rtl/jwf_window.sv
module jwf_window #(
    parameter int CW = 9,
    parameter int G  = 8,
    parameter int C  = 4,
    parameter int NT = 7,
    parameter int SW = 14,
    parameter int CB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [G*G*CW-1:0] tw_flat,
    input  logic [NT*SW-1:0]  thr_flat,
    output logic              out_valid,
    output logic [C*C*CB-1:0] code_flat
);
    localparam int OFS = (G - C) / 2;

    function automatic logic [SW-1:0] tw_at(input logic [G*G*CW-1:0] v, input int r, input int c);
        if (r < 0 || r >= G || c < 0 || c >= G) return '0;
        return SW'(v[(r*G+c)*CW +: CW]);
    endfunction

    logic [C*C*CB-1:0] code_d;

    for (genvar cr = 0; cr < C; cr++) begin : g_row
        for (genvar cc = 0; cc < C; cc++) begin : g_col
            localparam int R = cr + OFS;
            localparam int K = cc + OFS;
            logic [SW-1:0] s3 [3][3];
            logic [SW-1:0] e5;
            logic          is_max;
            logic [CB-1:0] hits;

            always_comb begin
                for (int dr = 0; dr < 3; dr++) begin
                    for (int dc = 0; dc < 3; dc++) begin
                        s3[dr][dc] = '0;
                        for (int i = -1; i <= 1; i++)
                            for (int j = -1; j <= 1; j++)
                                s3[dr][dc] = s3[dr][dc] + tw_at(tw_flat, R+dr-1+i, K+dc-1+j);
                    end
                end
                is_max = 1'b1;
                for (int n = 0; n < 9; n++) begin
                    if (n < 4) begin
                        if (!(s3[1][1] > s3[n/3][n%3])) is_max = 1'b0;
                    end else if (n > 4) begin
                        if (s3[1][1] < s3[n/3][n%3]) is_max = 1'b0;
                    end
                end
                e5 = '0;
                for (int i = -2; i <= 2; i++)
                    for (int j = -2; j <= 2; j++)
                        e5 = e5 + tw_at(tw_flat, R+i, K+j);
                hits = '0;
                for (int k = 0; k < NT; k++)
                    if (e5 >= thr_flat[k*SW +: SW]) hits = hits + CB'(1);
                code_d[(cr*C+cc)*CB +: CB] = is_max ? hits : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (in_valid) code_flat <= code_d;
    end
endmodule

// File: rtl/jwf_serializer.sv
module jwf_serializer
    import jwf_pkg::*;
#(
    parameter int NB = 48,
    parameter int WB = 12,
    localparam int NBW = $clog2(NB),
    localparam int WBW = $clog2(WB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_valid,
    input  logic [NB-1:0] frame,
    output logic          ser_bit,
    output logic          ser_valid,
    output logic          word_start
);
    ser_state_t     state, state_nx;
    logic [NB-1:0]  shreg;
    logic [NBW-1:0] bit_cnt;
    logic [WBW-1:0] word_cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            SER_IDLE: if (load_valid) state_nx = SER_SEND;
            SER_SEND: if (bit_cnt == NBW'(NB-1)) state_nx = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SER_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            word_cnt <= '0;
        end else begin
            unique case (state)
                SER_IDLE: begin
                    bit_cnt  <= '0;
                    word_cnt <= '0;
                    shreg    <= load_valid ? frame : '0;
                end
                SER_SEND: begin
                    shreg    <= shreg << 1;
                    bit_cnt  <= bit_cnt + NBW'(1);
                    word_cnt <= (word_cnt == WBW'(WB-1)) ? '0 : word_cnt + WBW'(1);
                end
            endcase
        end
    end

    always_comb begin
        ser_valid  = (state == SER_SEND);
        ser_bit    = ser_valid & shreg[NB-1];
        word_start = ser_valid & (word_cnt == '0);
    end
endmodule

// File: rtl/jet_window_finder.sv
module jet_window_finder #(
    parameter int TW = 8,
    parameter int G  = 8,
    parameter int C  = 4,
    parameter int NT = 7,
    localparam int CW = TW + 1,
    localparam int SW = CW + 5,
    localparam int CB = $clog2(NT + 1),
    localparam int WB = C * CB,
    localparam int NB = C * WB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [G*G*TW-1:0] em_flat,
    input  logic [G*G*TW-1:0] had_flat,
    input  logic [NT*SW-1:0]  thr_flat,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              word_start
);
    logic              tw_valid, code_valid;
    logic [G*G*CW-1:0] tw_flat;
    logic [C*C*CB-1:0] code_flat;
    logic [NB-1:0]     frame;

    jwf_tower_add #(.TW(TW), .G(G)) u_add (
        .clk(clk), .rst_n(rst_n), .in_valid(frame_valid),
        .em_flat(em_flat), .had_flat(had_flat),
        .out_valid(tw_valid), .tw_flat(tw_flat)
    );

    jwf_window #(.CW(CW), .G(G), .C(C), .NT(NT), .SW(SW), .CB(CB)) u_win (
        .clk(clk), .rst_n(rst_n), .in_valid(tw_valid),
        .tw_flat(tw_flat), .thr_flat(thr_flat),
        .out_valid(code_valid), .code_flat(code_flat)
    );

    for (genvar cr = 0; cr < C; cr++) begin : g_wr
        for (genvar cc = 0; cc < C; cc++) begin : g_wc
            assign frame[NB-1-(cr*WB+cc*CB) -: CB] = code_flat[(cr*C+cc)*CB +: CB];
        end
    end

    jwf_serializer #(.NB(NB), .WB(WB)) u_ser (
        .clk(clk), .rst_n(rst_n), .load_valid(code_valid), .frame(frame),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .word_start(word_start)
    );
endmodule

// File: rtl/jwf_checker.sv
module jwf_checker #(
    parameter int NB = 48
) (
    input logic clk,
    input logic rst_n,
    input logic frame_valid,
    input logic ser_bit,
    input logic ser_valid,
    input logic word_start
);
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n)         run <= '0;
        else if (ser_valid) run <= run + 16'd1;
        else                run <= '0;
    end

    AST_FIRST_BIT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> word_start); // R5

    AST_START_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |-> ser_valid); // R5

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> $past(frame_valid, 3)); // R6

    AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_valid) |-> run == 16'(NB)); // R6

    AST_NO_LONG_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> run < 16'(NB)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> !ser_bit); // R8
endmodule

bind jet_window_finder jwf_checker u_jwf_checker (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
    .ser_bit(ser_bit), .ser_valid(ser_valid), .word_start(word_start)
);

// File: tb/jet_window_finder_bench.sv
module jet_window_finder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 8, G = 8, C = 4, NT = 7, SW = 14, NB = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_valid = 1'b0;
    logic [G*G*TW-1:0] em_flat = '0, had_flat = '0;
    logic [NT*SW-1:0]  thr_flat = '0;
    logic ser_bit, ser_valid, word_start;

    int n_tests = 0, n_fail = 0;
    int em_m [G][G];
    int had_m [G][G];
    int thr_m [NT];
    int exp_code [C][C];
    logic [NB-1:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    jet_window_finder u_jet_window_finder (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .em_flat(em_flat), .had_flat(had_flat), .thr_flat(thr_flat),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .word_start(word_start)
    );

    task automatic check(input string tag, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int tow(input int r, input int c);
        if (r < 0 || r >= G || c < 0 || c >= G) return 0;
        return em_m[r][c] + had_m[r][c];
    endfunction

    function automatic int sum3(input int r, input int c);
        int s = 0;
        for (int i = -1; i <= 1; i++)
            for (int j = -1; j <= 1; j++) s += tow(r+i, c+j);
        return s;
    endfunction

    task automatic model();
        for (int cr = 0; cr < C; cr++) begin
            for (int cc = 0; cc < C; cc++) begin
                int r = cr + 2, c = cc + 2;
                int me = sum3(r, c);
                bit mx = 1;
                int e = 0, h = 0;
                if (!(me > sum3(r-1, c-1)) || !(me > sum3(r-1, c)) ||
                    !(me > sum3(r-1, c+1)) || !(me > sum3(r, c-1))) mx = 0;
                if (me < sum3(r, c+1) || me < sum3(r+1, c-1) ||
                    me < sum3(r+1, c) || me < sum3(r+1, c+1)) mx = 0;
                for (int i = -2; i <= 2; i++)
                    for (int j = -2; j <= 2; j++) e += tow(r+i, c+j);
                for (int k = 0; k < NT; k++) if (e >= thr_m[k]) h++;
                exp_code[cr][cc] = mx ? h : 0;
            end
        end
    endtask

    task automatic clear_inputs();
        for (int r = 0; r < G; r++)
            for (int c = 0; c < G; c++) begin em_m[r][c] = 0; had_m[r][c] = 0; end
    endtask

    task automatic pack_inputs();
        for (int r = 0; r < G; r++)
            for (int c = 0; c < G; c++) begin
                em_flat[(r*G+c)*TW +: TW]  = TW'(em_m[r][c]);
                had_flat[(r*G+c)*TW +: TW] = TW'(had_m[r][c]);
            end
        for (int k = 0; k < NT; k++) thr_flat[k*SW +: SW] = SW'(thr_m[k]);
    endtask

    // Drives one frame, optionally a second one at negedge number inject, and checks the burst.
    task automatic run_frame(input string tag, input int inject);
        model();
        pack_inputs();
        @(negedge clk);
        frame_valid = 1'b1;
        for (int n = 1; n <= 51; n++) begin
            @(negedge clk);
            frame_valid = (inject > 0 && n == inject);
            if (n == 2) check("R6 idle before first bit", int'(ser_valid), 0);
            if (n >= 3 && n <= 50) begin
                int b = n - 3;
                check("R6 ser_valid during burst", int'(ser_valid), 1);
                check("R5 word_start position", int'(word_start), (b % 12 == 0) ? 1 : 0);
                got[NB-1-b] = ser_bit;
            end
            if (n == 51) begin
                check("R6 idle after 48 bits", int'(ser_valid), 0);
                check("R8 bit low when idle", int'(ser_bit), 0);
            end
        end
        frame_valid = 1'b0;
        for (int cr = 0; cr < C; cr++)
            for (int cc = 0; cc < C; cc++)
                check($sformatf("%s code row%0d col%0d", tag, cr, cc),
                      int'(got[NB-1-(cr*12+cc*3) -: 3]), exp_code[cr][cc]);
    endtask

    task automatic t_reset();
        check("R8 reset ser_valid", int'(ser_valid), 0);
        check("R8 reset ser_bit", int'(ser_bit), 0);
        check("R8 reset word_start", int'(word_start), 0);
    endtask

    task automatic t_single_tower();
        clear_inputs();
        em_m[3][4] = 200; had_m[3][4] = 100;   // R1: 300 exceeds 8 bits
        thr_m = '{50, 100, 200, 299, 300, 301, 1000};
        run_frame("R1 single tower", 0);
    endtask

    task automatic t_plateau();
        clear_inputs();
        for (int r = 0; r < G; r++)
            for (int c = 0; c < G; c++) begin em_m[r][c] = 3; had_m[r][c] = 2; end
        thr_m = '{1, 2, 3, 4, 5, 6, 7};
        run_frame("R2 flat ties", 0);
    endtask

    task automatic t_two_peaks();
        clear_inputs();
        for (int r = 0; r < G; r++)
            for (int c = 0; c < G; c++) em_m[r][c] = (r * 7 + c * 3) % 5;
        em_m[2][2] = 40; had_m[2][3] = 30;
        em_m[5][5] = 60; had_m[5][4] = 20;
        thr_m = '{20, 40, 60, 80, 100, 120, 140};
        run_frame("R2 two peaks", 0);
    endtask

    task automatic t_corners();
        clear_inputs();
        em_m[0][0] = 100; had_m[7][7] = 90;
        em_m[3][3] = 10;  em_m[4][4] = 10;
        thr_m = '{5, 15, 25, 110, 115, 120, 130};
        run_frame("R3 corner towers", 0);
    endtask

    task automatic t_random(input int seed);
        int s = seed;
        clear_inputs();
        for (int r = 0; r < G; r++)
            for (int c = 0; c < G; c++) begin
                s = (s * 1103515245 + 12345) & 32'h7fffffff;
                em_m[r][c] = (s >> 8) & 255;
                had_m[r][c] = (s >> 16) & 255;
            end
        thr_m = '{3000, 500, 2500, 1500, 4000, 2000, 6000};
        run_frame("R4 random unsorted thresholds", 0);
    endtask

    task automatic t_busy(input int inject);
        clear_inputs();
        em_m[4][3] = 250; had_m[4][3] = 250;
        thr_m = '{100, 200, 300, 400, 500, 600, 700};
        run_frame($sformatf("R7 busy inject %0d", inject), inject);
        begin
            int seen = 0;
            for (int n = 0; n < 60; n++) begin
                @(negedge clk);
                if (ser_valid) seen++;
            end
            check("R7 no burst for dropped frame", seen, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        clear_inputs();
        thr_m = '{0, 0, 0, 0, 0, 0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_tower();
        t_plateau();
        t_two_peaks();
        t_corners();
        t_random(17);
        t_random(901);
        t_busy(5);
        t_busy(48);
        t_single_tower();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule